// File: doc/BRIEF.md
# Dot-Matrix Refresh Scanner with Dimming and Flash Gating

This block refreshes eight 5x7 LED digits. It scans the seven glyph rows one after another. For each row it fetches the code of every digit from an external character store. It looks up that digit's five dots for the coming row, either in a font table or in a user-character table; both tables sit outside the block and are reached through lookup ports. The fetched dots are held in a shadow buffer and shown during the next row period.

While a row is shown, the column bits are gated by three things:
- an eight-step dimming level, which trims the on-time within the row and leaves the peak drive unchanged;
- a per-digit flash mask;
- a whole-display blink.

Flash and blink share one slow on/off phase. Blink wins over flash.

The core clock is either the block's own internal clock, which is also exported for other units, or an external clock taken from another unit. Several units that share a clock and a reset stay in step.

Top module: `dotmatrix_scan`

## Requirements
- R1: Each row period has 16 sub-slots, one clock each, numbered 0..15. `mode_ctl[2:0]` selects how many of sub-slots 0..14 light the columns, counted from sub-slot 0: 000→15, 001→12, 010→8, 011→6, 100→4, 101→3, 110→2, 111→0 (dark).
- R2: Sub-slot 15 is a blanking slot. In it, `row_en` and `col_out` are all zero, so a row change always passes through zero.
- R3: Counting starts on the third `core` clock edge after `rst_n` rises; call that edge 1. Rows are shown in the order 0,1,…,6 and then wrap. Row r is shown in sub-slots 0..14 after edge 16·n, where r = (n−1) mod 7, and only `row_en[r]` is high. Before edge 16 nothing is lit.
- R4: Digit d drives `col_out[5d+4:5d]`. If bit 7 of its code is 0, its dots are `font_bits` read with `font_code`=code[6:0]. If bit 7 is 1, its dots are `udc_bits` read with `udc_code`=code[3:0]. In both cases the row index (0..6) of the row being fetched is presented on `font_row`/`udc_row`.
- R5: The slow phase is "on" for the first 896 row periods after counting starts (14,336 clocks) and "off" for the next 896, giving a full period of 28,672 clocks. It changes only at row boundaries.
- R6: With `mode_ctl[3]`=1, a digit whose `flash_mask` bit is set is dark during the off phase. With `mode_ctl[3]`=0 the mask has no effect.
- R7: With `mode_ctl[4]`=1, every digit is dark during the off phase, whatever `mode_ctl[3]` and the mask hold.
- R8: A low `rst_n` clears all counters, the shadow buffers and the slow phase. After it is released, the timing of R3 and R5 starts again from edge 1.
- R9: With `clk_src_sel`=1 the core runs from `clk_int` and `clk_out` follows it. With `clk_src_sel`=0 the core runs from `clk_ext` and `clk_out` is held at 0.
- R10: At most one bit of `row_en` is high at any time, and `col_out` is nonzero only while a row is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | internal clock source |
| clk_ext | input | 1 | clock from another unit |
| clk_src_sel | input | 1 | 1: internal clock, exported; 0: external clock |
| rst_n | input | 1 | asynchronous active-low reset |
| mode_ctl | input | 5 | [2:0] dimming code, [3] flash enable, [4] blink enable |
| flash_mask | input | 8 | per-digit flash select |
| cram_addr | output | 3 | digit index being fetched |
| cram_data | input | 8 | code of that digit |
| font_code | output | 7 | font table character index |
| font_row | output | 3 | font table row index |
| font_bits | input | 5 | dots returned by the font table |
| udc_code | output | 4 | user-character index |
| udc_row | output | 3 | user-character row index |
| udc_bits | input | 5 | dots returned by the user-character table |
| clk_out | output | 1 | exported clock |
| row_en | output | 7 | one-hot row enables |
| col_out | output | 40 | column bits, 5 per digit |

## Verification
A vector walk through the first frame sweeps all eight dimming codes at sub-slots on both sides of each level's cut-off. This separates an off-by-one in the duty compare from a wrong table entry, and the same walk confirms the row order and the blanking slot. The character store holds a mix of font and user codes, and the font and user tables return different, row-dependent dots. A swapped source or a stale row index therefore shows up in the columns. Around the slow-phase edge, flash-only, blink-only, blink-plus-flash and flash-masked-but-disabled settings are applied. These tell apart priority, mask and phase errors. A mid-run reset and an external-clock run check the restart and the clock choice.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

  localparam int unsigned SLOT_COUNT = 16;
  localparam int unsigned BLANK_SLOT = SLOT_COUNT - 1;

  // lit sub-slots per row for each dimming code (out of 15 usable)
  function automatic logic [3:0] duty_slots(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'd0:    n = 4'd15;
      3'd1:    n = 4'd12;
      3'd2:    n = 4'd8;
      3'd3:    n = 4'd6;
      3'd4:    n = 4'd4;
      3'd5:    n = 4'd3;
      3'd6:    n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scan_clk_sel.sv
`timescale 1ns/1ps
module scan_clk_sel (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic sel,
  output logic core_clk,
  output logic clk_out
);
  assign core_clk = sel ? clk_int : clk_ext;
  assign clk_out  = sel & clk_int;
endmodule

// File: rtl/scan_timebase.sv
`timescale 1ns/1ps
module scan_timebase #(
  parameter  int ROWS      = 7,
  parameter  int SLOW_DIV  = 28672,
  localparam int RW        = $clog2(ROWS),
  localparam int HALF_ROWS = SLOW_DIV / (2 * scan_pkg::SLOT_COUNT),
  localparam int CW        = $clog2(HALF_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [3:0]    sub,
  output logic [RW-1:0] row_cur,
  output logic [RW-1:0] row_next,
  output logic          row_valid,
  output logic          boundary,
  output logic          slow_off
);
  logic [3:0]    sub_q, sub_d;
  logic [RW-1:0] row_q, row_d, row_nx;
  logic          valid_q, valid_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          off_q, off_d;
  logic          at_end;

  always_comb begin
    at_end  = (sub_q == 4'(scan_pkg::BLANK_SLOT));
    row_nx  = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    sub_d   = sub_q + 4'd1;
    row_d   = row_q;
    valid_d = valid_q;
    cnt_d   = cnt_q;
    off_d   = off_q;
    if (at_end) begin
      row_d   = row_nx;
      valid_d = 1'b1;
      if (cnt_q == CW'(HALF_ROWS - 1)) begin
        cnt_d = '0;
        off_d = ~off_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      row_q   <= RW'(ROWS - 1);
      valid_q <= 1'b0;
      cnt_q   <= '0;
      off_q   <= 1'b0;
    end else begin
      sub_q   <= sub_d;
      row_q   <= row_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
      off_q   <= off_d;
    end
  end

  assign sub       = sub_q;
  assign row_cur   = row_q;
  assign row_next  = row_nx;
  assign row_valid = valid_q;
  assign boundary  = at_end;
  assign slow_off  = off_q;
endmodule

// File: rtl/scan_fetch.sv
`timescale 1ns/1ps
module scan_fetch #(
  parameter  int DIGITS = 8,
  parameter  int ROWS   = 7,
  parameter  int DOTS   = 5,
  localparam int RW     = $clog2(ROWS),
  localparam int DW     = $clog2(DIGITS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             sub,
  input  logic [RW-1:0]          row_next,
  input  logic                   load_row,
  output logic [DW-1:0]          cram_addr,
  input  logic [7:0]             cram_data,
  output logic [6:0]             font_code,
  output logic [RW-1:0]          font_row,
  input  logic [DOTS-1:0]        font_bits,
  output logic [3:0]             udc_code,
  output logic [RW-1:0]          udc_row,
  input  logic [DOTS-1:0]        udc_bits,
  output logic [DIGITS*DOTS-1:0] glyphs
);
  logic            fetch_en;
  logic [DOTS-1:0] glyph_in;

  always_comb begin
    fetch_en  = (sub < 4'(DIGITS));
    cram_addr = sub[DW-1:0];
    font_code = cram_data[6:0];
    udc_code  = cram_data[3:0];
    font_row  = row_next;
    udc_row   = row_next;
    glyph_in  = cram_data[7] ? udc_bits : font_bits;
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [DOTS-1:0] pend_q, pend_d, show_q, show_d;
    logic            pend_en;

    always_comb begin
      pend_en = fetch_en && (cram_addr == DW'(d));
      pend_d  = pend_en  ? glyph_in : pend_q;
      show_d  = load_row ? pend_q   : show_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        show_q <= '0;
      end else begin
        pend_q <= pend_d;
        show_q <= show_d;
      end
    end

    assign glyphs[d*DOTS +: DOTS] = show_q;
  end
endmodule

// File: rtl/scan_gate.sv
`timescale 1ns/1ps
module scan_gate #(
  parameter  int DIGITS = 8,
  parameter  int ROWS   = 7,
  parameter  int DOTS   = 5,
  localparam int RW     = $clog2(ROWS)
) (
  input  logic [3:0]             sub,
  input  logic [RW-1:0]          row_cur,
  input  logic                   row_valid,
  input  logic                   slow_off,
  input  logic [4:0]             mode,
  input  logic [DIGITS-1:0]      flash_mask,
  input  logic [DIGITS*DOTS-1:0] glyphs,
  output logic [ROWS-1:0]        row_en,
  output logic [DIGITS*DOTS-1:0] col
);
  logic row_on, slot_lit;

  always_comb begin
    row_on   = row_valid && (sub != 4'(scan_pkg::BLANK_SLOT));
    slot_lit = row_on && (sub < scan_pkg::duty_slots(mode[2:0]));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_en[r] = row_on && (row_cur == RW'(r));
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_col
    logic dark;
    assign dark = slow_off && (mode[4] || (mode[3] && flash_mask[d]));
    assign col[d*DOTS +: DOTS] = (slot_lit && !dark) ? glyphs[d*DOTS +: DOTS] : '0;
  end
endmodule

// File: rtl/dotmatrix_scan.sv
`timescale 1ns/1ps
module dotmatrix_scan #(
  parameter  int DIGITS   = 8,
  parameter  int ROWS     = 7,
  parameter  int DOTS     = 5,
  parameter  int SLOW_DIV = 28672,
  localparam int RW       = $clog2(ROWS),
  localparam int DW       = $clog2(DIGITS)
) (
  input  logic                   clk_int,
  input  logic                   clk_ext,
  input  logic                   clk_src_sel,
  input  logic                   rst_n,
  input  logic [4:0]             mode_ctl,
  input  logic [DIGITS-1:0]      flash_mask,
  output logic [DW-1:0]          cram_addr,
  input  logic [7:0]             cram_data,
  output logic [6:0]             font_code,
  output logic [RW-1:0]          font_row,
  input  logic [DOTS-1:0]        font_bits,
  output logic [3:0]             udc_code,
  output logic [RW-1:0]          udc_row,
  input  logic [DOTS-1:0]        udc_bits,
  output logic                   clk_out,
  output logic [ROWS-1:0]        row_en,
  output logic [DIGITS*DOTS-1:0] col_out
);
  logic                   core_clk;
  logic [1:0]             rst_sync;
  logic                   core_rst_n;
  logic [3:0]             sub;
  logic [RW-1:0]          row_cur, row_next;
  logic                   row_valid, boundary, slow_off;
  logic [DIGITS*DOTS-1:0] glyphs;

  scan_clk_sel u_clk (
    .clk_int (clk_int),
    .clk_ext (clk_ext),
    .sel     (clk_src_sel),
    .core_clk(core_clk),
    .clk_out (clk_out)
  );

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  scan_timebase #(.ROWS(ROWS), .SLOW_DIV(SLOW_DIV)) u_time (
    .clk      (core_clk),
    .rst_n    (core_rst_n),
    .sub      (sub),
    .row_cur  (row_cur),
    .row_next (row_next),
    .row_valid(row_valid),
    .boundary (boundary),
    .slow_off (slow_off)
  );

  scan_fetch #(.DIGITS(DIGITS), .ROWS(ROWS), .DOTS(DOTS)) u_fetch (
    .clk      (core_clk),
    .rst_n    (core_rst_n),
    .sub      (sub),
    .row_next (row_next),
    .load_row (boundary),
    .cram_addr(cram_addr),
    .cram_data(cram_data),
    .font_code(font_code),
    .font_row (font_row),
    .font_bits(font_bits),
    .udc_code (udc_code),
    .udc_row  (udc_row),
    .udc_bits (udc_bits),
    .glyphs   (glyphs)
  );

  scan_gate #(.DIGITS(DIGITS), .ROWS(ROWS), .DOTS(DOTS)) u_gate (
    .sub       (sub),
    .row_cur   (row_cur),
    .row_valid (row_valid),
    .slow_off  (slow_off),
    .mode      (mode_ctl),
    .flash_mask(flash_mask),
    .glyphs    (glyphs),
    .row_en    (row_en),
    .col       (col_out)
  );
endmodule

// File: rtl/scan_checker.sv
`timescale 1ns/1ps
module scan_checker #(
  parameter int ROWS = 7,
  parameter int COLS = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_sel,
  input logic            clk_out,
  input logic [4:0]      mode,
  input logic            slow_off,
  input logic [ROWS-1:0] row_en,
  input logic [COLS-1:0] col
);
  a_r10_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en));

  a_r10_cols_need_row: assert property (@(posedge clk) disable iff (!rst_n)
    (col != '0) |-> (row_en != '0));

  a_r2_row_break: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en != '0) |=> (row_en == $past(row_en) || row_en == '0));

  a_r1_dark_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:0] == 3'b111) |-> (col == '0));

  a_r7_blink_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[4] && slow_off) |-> (col == '0));

  a_r9_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> !clk_out);
endmodule

bind dotmatrix_scan scan_checker #(.ROWS(ROWS), .COLS(DIGITS*DOTS)) u_scan_chk (
  .clk     (core_clk),
  .rst_n   (core_rst_n),
  .clk_sel (clk_src_sel),
  .clk_out (clk_out),
  .mode    (mode_ctl),
  .slow_off(slow_off),
  .row_en  (row_en),
  .col     (col_out)
);

// File: tb/test_dotmatrix_scan.sv
`timescale 1ns/1ps
module test_dotmatrix_scan;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        sel = 1'b1;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'd0;
  logic [7:0]  fmask = 8'd0;
  logic [2:0]  cram_addr;
  logic [7:0]  cram_data;
  logic [6:0]  font_code;
  logic [2:0]  font_row, udc_row;
  logic [4:0]  font_bits, udc_bits;
  logic [3:0]  udc_code;
  logic        clk_out;
  logic [6:0]  row_en;
  logic [39:0] col_out;
  logic        clk_int, clk_ext;

  logic [7:0] cram [8] = '{8'h41, 8'h53, 8'h85, 8'h7F, 8'h20, 8'h8A, 8'h30, 8'h0F};

  assign clk_int   = sel ? clk : 1'b0;
  assign clk_ext   = sel ? 1'b0 : clk;
  assign cram_data = cram[cram_addr];
  assign font_bits = font_code[4:0] ^ {2'b00, font_row};
  assign udc_bits  = {udc_code, 1'b1} ^ {2'b00, udc_row};

  always #(PER/2) clk = ~clk;

  dotmatrix_scan i_dotmatrix_scan (
    .clk_int(clk_int), .clk_ext(clk_ext), .clk_src_sel(sel), .rst_n(rst_n),
    .mode_ctl(mode), .flash_mask(fmask),
    .cram_addr(cram_addr), .cram_data(cram_data),
    .font_code(font_code), .font_row(font_row), .font_bits(font_bits),
    .udc_code(udc_code), .udc_row(udc_row), .udc_bits(udc_bits),
    .clk_out(clk_out), .row_en(row_en), .col_out(col_out)
  );

  int total = 0;
  int bad   = 0;
  int e     = 0;
  bit done  = 0;

  typedef struct packed {
    logic [15:0] tgt;
    logic [4:0]  cw;
    logic [3:0]  row;   // 15 = no row enabled
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{16'd17,  5'h00, 4'd0},  '{16'd20,  5'h01, 4'd0},  '{16'd29,  5'h01, 4'd0},
    '{16'd31,  5'h00, 4'd15}, '{16'd35,  5'h02, 4'd1},  '{16'd44,  5'h02, 4'd1},
    '{16'd50,  5'h03, 4'd2},  '{16'd54,  5'h04, 4'd2},  '{16'd67,  5'h05, 4'd3},
    '{16'd81,  5'h06, 4'd4},  '{16'd100, 5'h07, 4'd5},  '{16'd126, 5'h00, 4'd6},
    '{16'd130, 5'h08, 4'd0}
  };

  function automatic void model(input int ep, input logic [4:0] cw, input logic [7:0] fm,
                                output logic [39:0] c, output logic [6:0] re);
    int n, s, r, lvl;
    logic ph;
    logic [7:0] code;
    logic [4:0] g;
    c = '0; re = '0;
    if (ep < 16) return;
    n = ep / 16; s = ep % 16; r = (n - 1) % 7;
    if (s == 15) return;
    re = 7'(1 << r);
    case (cw[2:0])
      3'd0: lvl = 15; 3'd1: lvl = 12; 3'd2: lvl = 8; 3'd3: lvl = 6;
      3'd4: lvl = 4;  3'd5: lvl = 3;  3'd6: lvl = 2; default: lvl = 0;
    endcase
    if (s >= lvl) return;
    ph = ((n / 896) % 2) == 1;
    for (int d = 0; d < 8; d++) begin
      code = cram[d];
      g = code[7] ? ({code[3:0], 1'b1} ^ 5'(r)) : (code[4:0] ^ 5'(r));
      if (!(ph && (cw[4] || (cw[3] && fm[d])))) c[d*5 +: 5] = g;
    end
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    sel   = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e = 0;
  endtask

  // move to counting edge tgt (two synchronizer edges precede edge 1)
  task automatic go(input int tgt);
    while (e < tgt + 2) begin
      @(posedge clk);
      e++;
    end
    #(PER/4);
  endtask

  task automatic expect_at(input string tag, input int tgt);
    logic [39:0] ec;
    logic [6:0]  er;
    go(tgt);
    model(tgt, mode, fmask, ec, er);
    check({tag, " row"}, {33'd0, row_en}, {33'd0, er});
    check({tag, " col"}, col_out, ec);
  endtask

  initial begin
    do_reset(1'b1);
    #1;
    check("R8 reset rows", {33'd0, row_en}, 40'd0);
    check("R8 reset cols", col_out, 40'd0);
    expect_at("R3 before first row", 15);

    for (int i = 0; i < 13; i++) begin
      logic [6:0] er;
      mode = VECS[i].cw;
      expect_at("R1 R4 vector", int'(VECS[i].tgt));
      er = (VECS[i].row == 4'd15) ? 7'd0 : 7'(1 << VECS[i].row);
      check("R3 R2 table row", {33'd0, row_en}, {33'd0, er});
    end

    mode = 5'h10; fmask = 8'h00;
    expect_at("R5 still on phase", 14330);
    mode = 5'h08; fmask = 8'h05;
    expect_at("R6 flash off phase", 14371);
    check("R6 digit1 lit", {35'd0, col_out[9:5]}, {35'd0, 5'(8'h53) ^ 5'd1});
    mode = 5'h00; fmask = 8'hFF;
    expect_at("R6 mask ignored", 14372);
    mode = 5'h10; fmask = 8'h00;
    expect_at("R7 blink dark", 14373);
    mode = 5'h18; fmask = 8'h00;
    expect_at("R7 blink over flash", 14374);
    mode = 5'h10;
    expect_at("R5 phase back on", 28690);

    @(posedge clk); #1;
    check("R9 clk_out high", {39'd0, clk_out}, 40'd1);
    #(PER/2);
    check("R9 clk_out low", {39'd0, clk_out}, 40'd0);

    mode = 5'h00;
    do_reset(1'b1);
    expect_at("R8 restart idle", 10);
    expect_at("R8 restart row0", 18);

    do_reset(1'b0);
    @(posedge clk); #1;
    check("R9 ext clk_out quiet", {39'd0, clk_out}, 40'd0);
    e++;
    expect_at("R9 ext clock scan", 19);
    expect_at("R9 ext clock row1", 37);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 120000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule